// File: doc/BRIEF.md
# Dual-Compare Continuous Pulse Generator

This block is one output-compare channel that emits an endless train of pulses on a single output pin. It has its own up-counting time base that wraps at a programmable period. It also holds two compare values. A match on the first value starts a high phase one instruction cycle later. A match on the second value ends the high phase at once. Two instruction cycles after each falling edge, the block raises a sticky interrupt flag. The flag stays set until a dedicated clear strobe removes it.

Software programs the channel through a narrow write port that addresses four registers: period, rise compare, fall compare and mode. A 3-bit mode value of 3'b101 enables pulse-train operation. Every other value parks the pin low. The time base has its own enable. All timing moves only on clock cycles where the instruction-cycle strobe `tick` is high, so the block can run from a fast clock with a slower instruction rate.

Top module: `dcp_pulse_gen`

## Requirements
- R1: A synchronous active-high `rst` clears the counter to 0, drives `pin_out` low, clears `irq_flag`, sets the mode to 0 (off) and the period to all ones, and clears both compare values.
- R2: When `wr_en` is high, `wr_sel` picks the register that `wr_data` is written to: 0 period, 1 rise compare, 2 fall compare, 3 mode (low 3 bits). A written value is used from the next cycle on.
- R3: On a cycle with `tick` and `tb_en` both high, the counter steps to 0 if its value is equal to or above the period. Otherwise it increments by one.
- R4: On a cycle with `tick` low, the counter, the pin and the interrupt pipeline do not change.
- R5: Any mode value other than 3'b101 drives `pin_out` low on the next clock cycle. It also cancels any pending rise or pending interrupt. The flag is then never set by a fall that occurred before the mode was left.
- R6: In mode 3'b101, the tick on which the counter equals the rise compare arms a rise. `pin_out` goes high on the following tick.
- R7: In mode 3'b101, `pin_out` is driven low on the tick on which the counter equals the fall compare. If that tick also carries an armed rise, the fall wins.
- R8: With rise compare A below fall compare B and B at most the period, the pin is high exactly while the counter's previous value lies strictly between A and B. This repeats every period without software action.
- R9: If the fall compare exceeds the period, no falling edge occurs and the pin stays high. Writing a fall compare at or below the period restores the falling edge within one period.
- R10: `irq_flag` is set on the second tick after a tick on which the pin fell from high. It then remains set while `irq_clr` is low.
- R11: `irq_clr` clears the flag on the next cycle. A set event in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Instruction-cycle enable |
| tb_en | input | 1 | Time-base count enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 period, 1 rise, 2 fall, 3 mode |
| wr_data | input | W | Write data |
| irq_clr | input | 1 | Interrupt flag clear strobe |
| pin_out | output | 1 | Pulse output |
| irq_flag | output | 1 | Sticky interrupt flag |
| tb_count | output | W | Current time-base value |

## Verification
The bench builds the block with W=4. This lets it sweep every period from 2 to 7, every rise compare below the period, and every fall compare from just above the rise compare to two beyond the period. That range covers the adjacent-compare collision, a fall exactly at the wrap point, and a fall compare that is never reached. Each sweep point's pin, flag and counter values follow from modular arithmetic on the edge index. Directed runs on the same small width cover tick gaps, leaving the mode while high or with an interrupt pending, lowering the fall compare while stuck high, and clear-versus-set collisions.

// File: rtl/dcp_pkg.sv
package dcp_pkg;
  typedef enum logic [1:0] {
    SEL_PERIOD = 2'd0,
    SEL_RISE   = 2'd1,
    SEL_FALL   = 2'd2,
    SEL_MODE   = 2'd3
  } reg_sel_t;

  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_PULSE_TRAIN = 3'b101;
endpackage

// File: rtl/dcp_regs.sv
module dcp_regs
  import dcp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      period_q,
  output logic [W-1:0]      rise_q,
  output logic [W-1:0]      fall_q,
  output logic [MODE_W-1:0] mode_q
);
  reg_sel_t sel;
  assign sel = reg_sel_t'(wr_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= '1;
      rise_q   <= '0;
      fall_q   <= '0;
      mode_q   <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_PERIOD: period_q <= wr_data;
        SEL_RISE:   rise_q   <= wr_data;
        SEL_FALL:   fall_q   <= wr_data;
        default:    mode_q   <= wr_data[MODE_W-1:0];
      endcase
    end
  end
endmodule

// File: rtl/dcp_timebase.sv
module dcp_timebase #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic [W-1:0] period,
  output logic [W-1:0] count
);
  // Next counter value: wraps to zero at or past the period.
  function automatic logic [W-1:0] advance(input logic [W-1:0] cur,
                                           input logic [W-1:0] per);
    return (cur >= per) ? '0 : cur + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (step) count <= advance(count, period);
  end
endmodule

// File: rtl/dcp_edge_seq.sv
module dcp_edge_seq #(
  parameter int IRQ_LAG = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic active,
  input  logic rise_hit,
  input  logic fall_hit,
  input  logic irq_clr,
  output logic pin,
  output logic rise_pend,
  output logic fall_evt,
  output logic irq_flag
);
  logic [IRQ_LAG-1:0] lag_q;
  logic               irq_set;

  assign fall_evt = fall_hit && pin;
  assign irq_set  = active && tick && lag_q[IRQ_LAG-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      pin       <= 1'b0;
      rise_pend <= 1'b0;
      lag_q     <= '0;
    end else if (!active) begin
      pin       <= 1'b0;
      rise_pend <= 1'b0;
      lag_q     <= '0;
    end else if (tick) begin
      if (fall_hit)       pin <= 1'b0;
      else if (rise_pend) pin <= 1'b1;
      rise_pend <= rise_hit;
      lag_q     <= (lag_q << 1) | IRQ_LAG'(fall_evt);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          irq_flag <= 1'b0;
    else if (irq_set) irq_flag <= 1'b1;
    else if (irq_clr) irq_flag <= 1'b0;
  end
endmodule

// File: rtl/dcp_pulse_gen.sv
module dcp_pulse_gen
  import dcp_pkg::*;
#(
  parameter int W       = 16,
  parameter int IRQ_LAG = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         tb_en,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         irq_clr,
  output logic         pin_out,
  output logic         irq_flag,
  output logic [W-1:0] tb_count
);
  logic [W-1:0]      period_q, rise_q, fall_q;
  logic [MODE_W-1:0] mode_q;
  logic              step, active, rise_hit, fall_hit, rise_pend, fall_evt;

  dcp_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .period_q(period_q), .rise_q(rise_q), .fall_q(fall_q), .mode_q(mode_q)
  );

  assign step = tick && tb_en;

  dcp_timebase #(.W(W)) u_tb (
    .clk(clk), .rst(rst), .step(step), .period(period_q), .count(tb_count)
  );

  assign active   = (mode_q == MODE_PULSE_TRAIN);
  assign rise_hit = active && step && (tb_count == rise_q);
  assign fall_hit = active && step && (tb_count == fall_q);

  dcp_edge_seq #(.IRQ_LAG(IRQ_LAG)) u_seq (
    .clk(clk), .rst(rst), .tick(tick), .active(active),
    .rise_hit(rise_hit), .fall_hit(fall_hit), .irq_clr(irq_clr),
    .pin(pin_out), .rise_pend(rise_pend), .fall_evt(fall_evt),
    .irq_flag(irq_flag)
  );
endmodule

// File: rtl/dcp_pulse_gen_chk.sv
module dcp_pulse_gen_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic         step,
  input logic         active,
  input logic         pin,
  input logic         flag,
  input logic         irq_clr,
  input logic [W-1:0] count,
  input logic [W-1:0] period,
  input logic         fall_hit,
  input logic         rise_pend
);
  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    step && count == period |=> count == '0);

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count) && $stable(pin));

  p_idle_low_r5: assert property (@(posedge clk) disable iff (rst)
    !active |=> !pin);

  p_rise_src_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(pin) |-> $past(rise_pend));

  p_fall_src_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(pin) && $past(active) |-> $past(fall_hit));

  p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    flag && !irq_clr |=> flag);
endmodule

bind dcp_pulse_gen dcp_pulse_gen_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .step(step), .active(active),
  .pin(pin_out), .flag(irq_flag), .irq_clr(irq_clr), .count(tb_count),
  .period(period_q), .fall_hit(fall_hit), .rise_pend(rise_pend)
);

// File: tb/sim_dcp_pulse_gen.sv
`timescale 1ns/1ps
module sim_dcp_pulse_gen;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick = 1'b0, tb_en = 1'b0, wr_en = 1'b0, irq_clr = 1'b0;
  logic [1:0]   wr_sel = '0;
  logic [W-1:0] wr_data = '0;
  logic         pin_out, irq_flag;
  logic [W-1:0] tb_count;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  dcp_pulse_gen #(.W(W)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .tb_en(tb_en), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .irq_clr(irq_clr),
    .pin_out(pin_out), .irq_flag(irq_flag), .tb_count(tb_count)
  );

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic edge1();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    tick = 0; tb_en = 0; irq_clr = 0; rst = 1;
    edge1();
    edge1();
    rst = 0;
  endtask

  task automatic wr(input int sel, input int data);
    @(negedge clk);
    wr_en = 1; wr_sel = 2'(sel); wr_data = W'(data);
    edge1();
    wr_en = 0;
  endtask

  task automatic setup(input int per, input int a, input int b, input int mode);
    do_reset();
    wr(0, per); wr(1, a); wr(2, b); wr(3, mode);
    tick = 1; tb_en = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got 0 expected 1 (run completed)");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit seen_low;
    do_reset();
    // R1: reset state
    check("R1 count", tb_count, 0);
    check("R1 pin", pin_out, 0);
    check("R1 flag", irq_flag, 0);

    // R2 R3 R6 R7 R8 R9 R10: sweep over period, rise and fall compares
    for (int per = 2; per <= 7; per++)
      for (int a = 0; a < per; a++)
        for (int b = a + 1; b <= per + 2; b++) begin
          setup(per, a, b, 5);
          for (int k = 1; k <= 2 * (per + 1) + 4; k++) begin
            int p, ep, ef;
            edge1();
            p = (k - 1) % (per + 1);
            if (b > per)           ep = (k >= a + 2) ? 1 : 0;
            else if (b >= a + 2)   ep = (p > a && p < b) ? 1 : 0;
            else                   ep = 0;
            ef = (b <= per && b >= a + 2 && k >= b + 3) ? 1 : 0;
            check("R3 count", tb_count, k % (per + 1));
            check("R8 pin", pin_out, ep);
            check("R10 flag", irq_flag, ef);
          end
        end

    // R9: fall compare beyond period, then lowered
    setup(5, 1, 9, 5);
    repeat (12) edge1();
    check("R9 stuck high", pin_out, 1);
    wr(2, 3);
    seen_low = 0;
    for (int i = 0; i < 6; i++) begin
      edge1();
      if (!pin_out) seen_low = 1;
    end
    check("R9 recovered fall", seen_low, 1);

    // R4: tick gaps freeze everything
    setup(7, 1, 5, 5);
    repeat (3) edge1();
    check("R4 pre count", tb_count, 3);
    check("R4 pre pin", pin_out, 1);
    tick = 0;
    for (int i = 0; i < 6; i++) begin
      edge1();
      check("R4 hold count", tb_count, 3);
      check("R4 hold pin", pin_out, 1);
    end
    tick = 1;
    edge1();
    check("R4 resume count", tb_count, 4);

    // R5: leaving mode while high forces low one cycle after the write
    setup(7, 1, 6, 5);
    repeat (4) edge1();
    wr_en = 1; wr_sel = 2'd3; wr_data = '0;
    edge1();
    wr_en = 0;
    check("R5 still high", pin_out, 1);
    edge1();
    check("R5 forced low", pin_out, 0);

    // R5: leaving mode after a fall cancels the pending interrupt
    setup(7, 1, 3, 5);
    repeat (4) edge1();
    wr_en = 1; wr_sel = 2'd3; wr_data = '0;
    edge1();
    wr_en = 0;
    for (int i = 0; i < 8; i++) edge1();
    check("R5 irq cancelled", irq_flag, 0);

    // R5: non-pulse mode value keeps pin low
    setup(4, 0, 2, 4);
    seen_low = 1;
    for (int i = 0; i < 15; i++) begin
      edge1();
      if (pin_out || irq_flag) seen_low = 0;
    end
    check("R5 other mode idle", seen_low, 1);

    // R11: set beats a clear held high, then clear takes effect
    setup(6, 0, 2, 5);
    irq_clr = 1;
    repeat (5) edge1();
    check("R11 set over clear", irq_flag, 1);
    edge1();
    check("R11 cleared", irq_flag, 0);
    irq_clr = 0;
    repeat (7) edge1();
    check("R10 set again", irq_flag, 1);
    irq_clr = 1;
    edge1();
    irq_clr = 0;
    check("R11 clear strobe", irq_flag, 0);

    // R1: reset mid-run, then mode stays off
    @(negedge clk);
    rst = 1;
    edge1();
    rst = 0;
    check("R1 mid count", tb_count, 0);
    check("R1 mid pin", pin_out, 0);
    check("R1 mid flag", irq_flag, 0);
    repeat (8) edge1();
    check("R1 mode off after reset", pin_out, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule